// File: doc/BRIEF.md
# Bus Clock Stop Controller

This block takes a bus clock phase that is already divided down from a fast reference clock and produces two kinds of output. The first is a free-running copy of that bus clock. The second is a group of gated copies that a low-power request can stop. All logic runs in the reference clock domain, and every output is a register clocked by the reference. The outputs are therefore clean levels that keep the same edge spacing as the bus phase.

The stop request is active low and asynchronous. A global enable, also asynchronous and active high, qualifies it. Both pass through synchronizers before they can affect anything. The gate enable only changes while the bus phase is low. As a result, a gated output parks low, restarts with a complete high phase, and never produces a shortened pulse. Stopping takes effect after one more bus pulse. Restarting takes effect on the third bus rising edge.

Top module: `bus_clk_stop`

## Requirements
- R1: `bus_free_o` equals `bus_phase_i` delayed by one reference cycle, whatever the stop request and global enable do. Each of its high phases keeps the width of the bus phase high phase.
- R2: `stop_n_i` and `glob_en_i` are each synchronized through SYNC_STAGES reference flops (default 2). A change applied between reference rising edges k and k+1 first influences gating at edge k+3, which is called the effective edge.
- R3: A gated output is high only while `bus_free_o` is high. The gate state changes only while the bus phase is low, so every gated high phase is either absent or exactly as wide as the matching free-running high phase.
- R4: A bus rising edge is a reference edge at which `bus_phase_i` is sampled 1 after being sampled 0 at the previous edge. After the effective edge of a release (the request goes back high, or the global enable goes low while the request is low), the first two bus rising edges produce no gated pulse. The gated outputs restart on the third.
- R5: After the effective edge of a stop (request low while the global enable is high), the gated pulse that starts at the first bus rising edge is still delivered in full. No gated pulse follows it.
- R6: While `glob_en_i` is low, a low `stop_n_i` is ignored and the gated outputs keep running. Raising `glob_en_i` while the request is held low stops them with the latency of R5.
- R7: While `rst_n_i` is low, all outputs are low. After reset the gated outputs are in the running state.
- R8: All bits of `bus_gated_o` are equal at every reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Fast reference clock; all state is clocked by it |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| bus_phase_i | input | 1 | Bus clock phase derived from the reference, synchronous to it |
| stop_n_i | input | 1 | Asynchronous stop request, active low |
| glob_en_i | input | 1 | Asynchronous global enable, active high; the stop request acts only when it is 1 |
| bus_free_o | output | 1 | Free-running bus clock |
| bus_gated_o | output | N_OUT | Gated bus clocks, parked low when stopped |

## Verification
The hardest case is a request change whose effective edge falls exactly on, or right next to, a bus rising edge. In that case the on and off pulse counts differ by a whole pulse depending on one reference cycle. The bench applies every request and enable change at a random offset inside a reference cycle, after a random number of cycles, while the bus phase runs at a fixed period. Over many toggles the effective edge therefore lands at every position within the bus period. A scoreboard records the effective edge of each change, and the monitor checks every reference cycle against the counted bus rising edges. The global-enable sequence also covers the case where the stop is armed by the enable rather than by the request.

// File: rtl/bus_clk_stop.sv
module bus_clk_stop #(
  parameter int N_OUT       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int ON_EDGES    = 3,
  parameter int OFF_EDGES   = 1
) (
  input  logic             clk_ref_i,
  input  logic             rst_n_i,
  input  logic             bus_phase_i,
  input  logic             stop_n_i,
  input  logic             glob_en_i,
  output logic             bus_free_o,
  output logic [N_OUT-1:0] bus_gated_o
);
  localparam int MAX_E = (ON_EDGES > OFF_EDGES) ? ON_EDGES : OFF_EDGES;
  localparam int CNT_W = $clog2(MAX_E + 1);
  localparam logic [CNT_W-1:0] ON_NEED  = CNT_W'(ON_EDGES - 1);
  localparam logic [CNT_W-1:0] OFF_NEED = CNT_W'(OFF_EDGES);

  logic [SYNC_STAGES-1:0] stop_sh, glob_sh;
  logic                   stop_s, glob_s, want_run;
  logic                   bus_d, rise, en;
  logic [CNT_W-1:0]       cnt, need;

  // two-flop style synchronizers, reset to the "run" view
  always_ff @(posedge clk_ref_i or negedge rst_n_i)
    if (!rst_n_i) begin
      stop_sh <= '1;
      glob_sh <= '0;
    end else begin
      stop_sh <= SYNC_STAGES'({stop_sh, stop_n_i});
      glob_sh <= SYNC_STAGES'({glob_sh, glob_en_i});
    end

  assign stop_s   = stop_sh[SYNC_STAGES-1];
  assign glob_s   = glob_sh[SYNC_STAGES-1];
  assign want_run = ~(glob_s & ~stop_s);
  assign rise     = bus_phase_i & ~bus_d;
  assign need     = en ? OFF_NEED : ON_NEED;

  // latency counter and gate enable; enable moves only in a low phase
  always_ff @(posedge clk_ref_i or negedge rst_n_i)
    if (!rst_n_i) begin
      bus_d <= 1'b0;
      en    <= 1'b1;
      cnt   <= '0;
    end else begin
      bus_d <= bus_phase_i;
      if (want_run == en)
        cnt <= '0;
      else if (cnt >= need && !bus_phase_i) begin
        en  <= ~en;
        cnt <= '0;
      end else if (rise && cnt < need)
        cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk_ref_i or negedge rst_n_i)
    if (!rst_n_i) begin
      bus_free_o  <= 1'b0;
      bus_gated_o <= '0;
    end else begin
      bus_free_o  <= bus_phase_i;
      bus_gated_o <= {N_OUT{bus_phase_i & en}};
    end

  a_r3_park_low: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
    !bus_free_o |-> bus_gated_o == '0);
  a_r3_hold_high: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
    (bus_free_o && $past(bus_free_o)) |-> $stable(bus_gated_o));
  a_r3_edge_low: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
    !$stable(en) |-> !$past(bus_phase_i));
  a_r4_on_cause: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
    $rose(en) |-> $past(want_run));
  a_r5_off_cause: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
    $fell(en) |-> !$past(want_run));
  a_r6_glob_gate: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
    $fell(en) |-> $past(glob_s));
  a_r8_all_same: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
    bus_gated_o == '0 || bus_gated_o == '1);
endmodule

// File: tb/bus_clk_stop_bench.sv
module bus_clk_stop_bench;
  localparam int N_OUT = 7;
  localparam int HALF  = 3;

  typedef struct { int eff; logic want; } item_t;

  logic clk = 0, rst_n = 0, bus_phase = 0, stop_n = 1, glob_en = 1;
  logic             bus_free;
  logic [N_OUT-1:0] bus_gated;

  bus_clk_stop #(.N_OUT(N_OUT)) u_bus_clk_stop (
    .clk_ref_i(clk), .rst_n_i(rst_n), .bus_phase_i(bus_phase),
    .stop_n_i(stop_n), .glob_en_i(glob_en),
    .bus_free_o(bus_free), .bus_gated_o(bus_gated));

  initial forever #5 clk = ~clk;

  initial begin
    int hc = 0;
    forever begin
      @(negedge clk);
      if (hc == HALF - 1) begin bus_phase <= ~bus_phase; hc = 0; end
      else hc = hc + 1;
    end
  end

  int   edge_no = 0;
  logic bus_at_edge = 0, bus_prev = 0, rst_at_edge = 0;
  always @(posedge clk) begin
    edge_no     <= edge_no + 1;
    bus_prev    <= bus_at_edge;
    bus_at_edge <= bus_phase;
    rst_at_edge <= rst_n;
  end

  item_t sb_q[$];
  int    n_vec = 0, n_bad = 0;
  bit    m_en = 1, m_want = 1, cur_pass = 1, glob_test = 0, seen_rise = 0, done = 0;
  int    m_cnt = 0, f_hi = 0, g_hi = 0;

  task automatic fail(input string tag, input string what, input int act, input int exp);
    n_bad++;
    $display("FAIL %s: %s actual=%0h expected=%0h (edge %0d)", tag, what, act, exp, edge_no);
  endtask

  // driver: R2 effective edge is three reference edges after the change
  task automatic drive(input logic s, input logic g);
    @(posedge clk);
    #($urandom_range(1, 4));
    stop_n  = s;
    glob_en = g;
    sb_q.push_back(item_t'{edge_no + 3, !(g && !s)});
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  // monitor: pops scoreboard items at their effective edge, compares each cycle
  always @(negedge clk) begin
    item_t            it;
    logic             rise;
    logic [N_OUT-1:0] exp_g;
    string            tag;
    if (!done) begin
      if (!rst_at_edge) begin
        n_vec++;
        if (bus_free !== 1'b0 || bus_gated !== '0)
          fail("R7", "outputs in reset", {bus_free, bus_gated}, 0);
        f_hi = 0; g_hi = 0;
      end else begin
        while (sb_q.size() > 0 && sb_q[0].eff <= edge_no) begin
          it = sb_q.pop_front();
          m_want = it.want;
          if (m_want == m_en) m_cnt = 0;
        end
        tag = glob_test ? "R6" : "R3";
        if (m_want != m_en) tag = m_en ? "R5 (R2 timing)" : "R4 (R2 timing)";
        rise = bus_at_edge && !bus_prev;
        if (rise) begin
          seen_rise = 1;
          if (m_want != m_en) m_cnt++;
          if (m_en) begin
            cur_pass = 1;
            if (!m_want && m_cnt >= 1) begin m_en = 0; m_cnt = 0; end
          end else if (m_want && m_cnt >= 3) begin
            m_en = 1; m_cnt = 0; cur_pass = 1;
          end else
            cur_pass = 0;
        end
        // R8: every gated bit is expected equal
        exp_g = (bus_at_edge && cur_pass) ? '1 : '0;
        n_vec++;
        if (bus_free !== bus_at_edge) fail("R1", "free clock", bus_free, bus_at_edge);
        if (bus_gated !== exp_g) fail(tag, "gated clocks", bus_gated, exp_g);
        if (bus_free === 1'b1) f_hi++;
        if (bus_gated[0] === 1'b1) g_hi++;
        if (!bus_at_edge && bus_prev) begin
          if (seen_rise) begin
            n_vec++;
            if (f_hi != HALF) fail("R1", "free high width", f_hi, HALF);
            n_vec++;
            if (g_hi != 0 && g_hi != HALF) fail("R3", "gated high width", g_hi, HALF);
          end
          f_hi = 0; g_hi = 0;
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (8) @(negedge clk);
    rst_n = 1;
    wait_cyc(120);
    // R4/R5 latencies, random placement against the bus phase
    for (int i = 0; i < 16; i++) begin
      drive(1'b0, 1'b1);
      wait_cyc($urandom_range(20, 70));
      drive(1'b1, 1'b1);
      wait_cyc($urandom_range(70, 110));
    end
    // R6: global enable qualifies the request
    glob_test = 1;
    drive(1'b1, 1'b0); wait_cyc(40);
    drive(1'b0, 1'b0); wait_cyc(80);
    drive(1'b0, 1'b1); wait_cyc(60);
    drive(1'b0, 1'b0); wait_cyc(80);
    drive(1'b1, 1'b0); wait_cyc(30);
    drive(1'b1, 1'b1); wait_cyc(80);
    glob_test = 0;
    // R7: reset mid-stop returns to running
    drive(1'b0, 1'b1); wait_cyc(40);
    @(negedge clk); rst_n = 0;
    sb_q.delete(); m_en = 1; m_want = 1; m_cnt = 0; cur_pass = 1; seen_rise = 0;
    wait_cyc(6);
    @(negedge clk);
    stop_n = 1;
    rst_n = 1;
    wait_cyc(100);
    finish_run();
  end
endmodule